// File: doc/BRIEF.md
# Register Status Flag File

This block is a small status store that sits beside a 16-entry, 16-bit data register file without holding any register data itself. It snoops every write into the data registers and keeps, for each register, a sign bit and a zero bit derived from the value just written. Because these bits always track the current register contents, they never need to be saved or restored on an interrupt or a task switch.

Next to the per-register bits it keeps dynamic status raised by the datapath: sticky overflow flags and loop status flags. Software must save and restore these explicitly. They can be read as one vector and reloaded in a single cycle.

Two identical query ports read the same stored status. One feeds predicated execution and the other feeds conditional branches. Each query names a data register and a 3-bit condition code and returns at once whether the condition holds for that register. Because predication is keyed on a named register, no dependency arises through a shared condition word.

Top module: `status_flag_file`

## Requirements
- R1: After reset every register reads as zero and not negative (zero flag 1, sign flag 0), and all dynamic flags read 0.
- R2: A short write (`sw_en`, index, 16-bit value) sets that register's sign flag to bit 15 of the value and its zero flag to (value == 0). No other register's flags change.
- R3: A long write to pair p updates register 2p from bits 15:0 and register 2p+1 from bits 31:16, each from its own half.
- R4: If the short and long ports write the same register in one cycle, the short write decides that register's flags.
- R5: Condition codes are: 0 always, 1 zero (Z), 2 nonzero (!Z), 3 negative (S), 4 non-negative (!S), 5 positive (!S and !Z), 6 less-or-equal (S or Z), 7 overflow (any stored overflow flag is set).
- R6: A query sees a register write made in the same cycle, before the clock edge.
- R7: An overflow flag, once set, stays set until its own clear strobe arrives. If set and clear arrive in the same cycle, the flag ends up set.
- R8: The loop status write updates only the loop flags selected by its mask, each to the matching data bit.
- R9: `dyn_flags` is {loop flags, overflow flags} with overflow in the low bits. A restore load writes all of them at once and takes priority over datapath updates in that cycle.
- R10: The predicate port and the branch port evaluate the same stored status independently, each for its own register and condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_en | input | 1 | Short register write strobe |
| sw_idx | input | 4 | Register written by the short port |
| sw_data | input | 16 | Value written by the short port |
| lw_en | input | 1 | Long register-pair write strobe |
| lw_pair | input | 3 | Pair index p (registers 2p, 2p+1) |
| lw_data | input | 32 | Value written to the pair |
| ovf_set | input | 4 | Per-flag overflow set strobes |
| ovf_clr | input | 4 | Per-flag overflow clear strobes |
| loop_mask | input | 4 | Loop flags to update |
| loop_val | input | 4 | New loop flag values |
| rst_ld_en | input | 1 | Restore load strobe for all dynamic flags |
| rst_ld_val | input | 8 | Restore value, {loop, overflow} |
| dyn_flags | output | 8 | Current dynamic flags, {loop, overflow} |
| pq_idx | input | 4 | Predicate query register |
| pq_cc | input | 3 | Predicate query condition code |
| pq_true | output | 1 | Predicate query result |
| bq_idx | input | 4 | Branch query register |
| bq_cc | input | 3 | Branch query condition code |
| bq_take | output | 1 | Branch query result |

## Verification
The capture path is tested with negative, positive, zero and all-ones values. The mix tells the sign decision apart from the zero decision and shows whether the positive and less-or-equal codes combine them correctly. Long writes carry halves that differ in sign and zeroness, which shows whether each half is steered to its own register. A collision case shows port priority. Queries made before the clock edge separate write-through from registered reads. For the dynamic flags, the bench sends set, clear, set-with-clear and restore-with-set patterns, which separate stickiness, set priority and restore priority.

// File: rtl/rff_pkg.sv
package rff_pkg;

  typedef enum logic [2:0] {
    CC_ALWAYS  = 3'd0,
    CC_ZERO    = 3'd1,
    CC_NONZERO = 3'd2,
    CC_NEG     = 3'd3,
    CC_NONNEG  = 3'd4,
    CC_POS     = 3'd5,
    CC_LE      = 3'd6,
    CC_OVF     = 3'd7
  } cond_e;

  typedef struct packed {
    logic sign;
    logic zero;
  } rflag_t;

  // condition evaluation against one register's flags
  function automatic logic cond_eval(input rflag_t f, input logic any_ovf, input cond_e cc);
    logic r;
    case (cc)
      CC_ALWAYS:  r = 1'b1;
      CC_ZERO:    r = f.zero;
      CC_NONZERO: r = !f.zero;
      CC_NEG:     r = f.sign;
      CC_NONNEG:  r = !f.sign;
      CC_POS:     r = !f.sign && !f.zero;
      CC_LE:      r = f.sign || f.zero;
      default:    r = any_ovf;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rff_capture.sv
module rff_capture
  import rff_pkg::*;
#(
  parameter int NREG = 16,
  parameter int DW   = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sw_en,
  input  logic [$clog2(NREG)-1:0] sw_idx,
  input  logic [DW-1:0]           sw_data,
  input  logic                    lw_en,
  input  logic [$clog2(NREG)-2:0] lw_pair,
  input  logic [2*DW-1:0]         lw_data,
  output logic [NREG-1:0]         sign_now,
  output logic [NREG-1:0]         zero_now,
  output logic [NREG-1:0]         sign_q,
  output logic [NREG-1:0]         zero_q
);
  localparam int IDX_W  = $clog2(NREG);
  localparam int PAIR_W = IDX_W - 1;

  function automatic rflag_t derive(input logic [DW-1:0] v);
    rflag_t f;
    f.sign = v[DW-1];
    f.zero = (v == '0);
    return f;
  endfunction

  logic [NREG-1:0] hit_short;
  logic [NREG-1:0] hit_long;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DW-1:0] half;
    rflag_t        nxt;
    assign hit_short[i] = sw_en && (sw_idx == IDX_W'(i));
    assign hit_long[i]  = lw_en && (lw_pair == PAIR_W'(i / 2));
    assign half         = lw_data[(i % 2)*DW +: DW];

    always_comb begin
      if (hit_short[i])     nxt = derive(sw_data);
      else if (hit_long[i]) nxt = derive(half);
      else                  nxt = '{sign: sign_q[i], zero: zero_q[i]};
    end

    assign sign_now[i] = nxt.sign;
    assign zero_now[i] = nxt.zero;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sign_q[i] <= 1'b0;
        zero_q[i] <= 1'b1;
      end else begin
        sign_q[i] <= nxt.sign;
        zero_q[i] <= nxt.zero;
      end
    end
  end

  assert_short_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sw_en |=> (zero_q[$past(sw_idx)] == ($past(sw_data) == '0)) &&
              (sign_q[$past(sw_idx)] == $past(sw_data[DW-1])));

  assert_long_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lw_en && !(sw_en && sw_idx[IDX_W-1:1] == lw_pair)) |=>
      (zero_q[{$past(lw_pair), 1'b0}] == ($past(lw_data[DW-1:0]) == '0)) &&
      (zero_q[{$past(lw_pair), 1'b1}] == ($past(lw_data[2*DW-1:DW]) == '0)));

  assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_en && !lw_en) |=> ($stable(sign_q) && $stable(zero_q)));

  assert_sign_zero_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sign_q & zero_q) == '0);

endmodule

// File: rtl/rff_dynamic.sv
module rff_dynamic #(
  parameter int OVF_N  = 4,
  parameter int LOOP_N = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [OVF_N-1:0]        ovf_set,
  input  logic [OVF_N-1:0]        ovf_clr,
  input  logic [LOOP_N-1:0]       loop_mask,
  input  logic [LOOP_N-1:0]       loop_val,
  input  logic                    ld_en,
  input  logic [OVF_N+LOOP_N-1:0] ld_val,
  output logic [OVF_N-1:0]        ovf_q,
  output logic [LOOP_N-1:0]       loop_q
);
  logic [OVF_N-1:0]  ovf_nxt;
  logic [LOOP_N-1:0] loop_nxt;

  always_comb begin
    if (ld_en) begin
      ovf_nxt  = ld_val[OVF_N-1:0];
      loop_nxt = ld_val[OVF_N +: LOOP_N];
    end else begin
      ovf_nxt  = (ovf_q & ~ovf_clr) | ovf_set;
      loop_nxt = (loop_q & ~loop_mask) | (loop_val & loop_mask);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q  <= '0;
      loop_q <= '0;
    end else begin
      ovf_q  <= ovf_nxt;
      loop_q <= loop_nxt;
    end
  end

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_en |=> ((($past(ovf_q) & ~$past(ovf_clr)) & ~ovf_q) == '0));

  assert_ovf_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_en |=> ((ovf_q & $past(ovf_set)) == $past(ovf_set)));

  assert_loop_unmasked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_en |=> (((loop_q ^ $past(loop_q)) & ~$past(loop_mask)) == '0));

  assert_restore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> ({loop_q, ovf_q} == $past(ld_val)));

endmodule

// File: rtl/rff_cond.sv
module rff_cond
  import rff_pkg::*;
#(
  parameter int NREG = 16
) (
  input  logic [NREG-1:0]         sign_v,
  input  logic [NREG-1:0]         zero_v,
  input  logic                    any_ovf,
  input  logic [$clog2(NREG)-1:0] idx,
  input  logic [2:0]              cc,
  output logic                    result
);
  rflag_t sel;

  always_comb begin
    sel.sign = sign_v[idx];
    sel.zero = zero_v[idx];
    result   = cond_eval(sel, any_ovf, cond_e'(cc));
  end

  always_comb begin
    if (cc == 3'd0) assert_always_true_R5: assert (result);
  end

endmodule

// File: rtl/status_flag_file.sv
module status_flag_file #(
  parameter int NREG   = 16,
  parameter int DW     = 16,
  parameter int OVF_N  = 4,
  parameter int LOOP_N = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sw_en,
  input  logic [$clog2(NREG)-1:0]   sw_idx,
  input  logic [DW-1:0]             sw_data,
  input  logic                      lw_en,
  input  logic [$clog2(NREG)-2:0]   lw_pair,
  input  logic [2*DW-1:0]           lw_data,
  input  logic [OVF_N-1:0]          ovf_set,
  input  logic [OVF_N-1:0]          ovf_clr,
  input  logic [LOOP_N-1:0]         loop_mask,
  input  logic [LOOP_N-1:0]         loop_val,
  input  logic                      rst_ld_en,
  input  logic [OVF_N+LOOP_N-1:0]   rst_ld_val,
  output logic [OVF_N+LOOP_N-1:0]   dyn_flags,
  input  logic [$clog2(NREG)-1:0]   pq_idx,
  input  logic [2:0]                pq_cc,
  output logic                      pq_true,
  input  logic [$clog2(NREG)-1:0]   bq_idx,
  input  logic [2:0]                bq_cc,
  output logic                      bq_take
);
  logic [NREG-1:0]   sign_now, zero_now, sign_q, zero_q;
  logic [OVF_N-1:0]  ovf_q;
  logic [LOOP_N-1:0] loop_q;
  logic              any_ovf;

  rff_capture #(.NREG(NREG), .DW(DW)) u_capture (
    .clk(clk), .rst_n(rst_n),
    .sw_en(sw_en), .sw_idx(sw_idx), .sw_data(sw_data),
    .lw_en(lw_en), .lw_pair(lw_pair), .lw_data(lw_data),
    .sign_now(sign_now), .zero_now(zero_now),
    .sign_q(sign_q), .zero_q(zero_q)
  );

  rff_dynamic #(.OVF_N(OVF_N), .LOOP_N(LOOP_N)) u_dynamic (
    .clk(clk), .rst_n(rst_n),
    .ovf_set(ovf_set), .ovf_clr(ovf_clr),
    .loop_mask(loop_mask), .loop_val(loop_val),
    .ld_en(rst_ld_en), .ld_val(rst_ld_val),
    .ovf_q(ovf_q), .loop_q(loop_q)
  );

  assign any_ovf   = |ovf_q;
  assign dyn_flags = {loop_q, ovf_q};

  rff_cond #(.NREG(NREG)) u_pred (
    .sign_v(sign_now), .zero_v(zero_now), .any_ovf(any_ovf),
    .idx(pq_idx), .cc(pq_cc), .result(pq_true)
  );

  rff_cond #(.NREG(NREG)) u_branch (
    .sign_v(sign_now), .zero_v(zero_now), .any_ovf(any_ovf),
    .idx(bq_idx), .cc(bq_cc), .result(bq_take)
  );

  assert_ports_agree_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pq_idx == bq_idx && pq_cc == bq_cc) |-> (pq_true == bq_take));

  assert_ovf_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pq_cc == 3'd7) |-> (pq_true == (dyn_flags[OVF_N-1:0] != '0)));

endmodule

// File: tb/tb_status_flag_file.sv
module tb_status_flag_file;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_en = 0;
  logic [3:0]  sw_idx = 0;
  logic [15:0] sw_data = 0;
  logic        lw_en = 0;
  logic [2:0]  lw_pair = 0;
  logic [31:0] lw_data = 0;
  logic [3:0]  ovf_set = 0, ovf_clr = 0, loop_mask = 0, loop_val = 0;
  logic        rst_ld_en = 0;
  logic [7:0]  rst_ld_val = 0;
  logic [7:0]  dyn_flags;
  logic [3:0]  pq_idx = 0, bq_idx = 0;
  logic [2:0]  pq_cc = 0, bq_cc = 0;
  logic        pq_true, bq_take;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit m_s[16];
  bit m_z[16];

  always #(PERIOD/2) clk = ~clk;

  status_flag_file dut (
    .clk(clk), .rst_n(rst_n),
    .sw_en(sw_en), .sw_idx(sw_idx), .sw_data(sw_data),
    .lw_en(lw_en), .lw_pair(lw_pair), .lw_data(lw_data),
    .ovf_set(ovf_set), .ovf_clr(ovf_clr),
    .loop_mask(loop_mask), .loop_val(loop_val),
    .rst_ld_en(rst_ld_en), .rst_ld_val(rst_ld_val), .dyn_flags(dyn_flags),
    .pq_idx(pq_idx), .pq_cc(pq_cc), .pq_true(pq_true),
    .bq_idx(bq_idx), .bq_cc(bq_cc), .bq_take(bq_take)
  );

  // expected condition, written from the code table
  function automatic bit expect_cc(bit s, bit z, bit ovf, int cc);
    bit neg_or_zero;
    neg_or_zero = s | z;
    if (cc == 0) return 1;
    if (cc == 1) return z;
    if (cc == 2) return ~z;
    if (cc == 3) return s;
    if (cc == 4) return ~s;
    if (cc == 5) return ~neg_or_zero;
    if (cc == 6) return neg_or_zero;
    return ovf;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    sw_en = 0; lw_en = 0; ovf_set = 0; ovf_clr = 0;
    loop_mask = 0; rst_ld_en = 0;
  endtask

  task automatic model_set(int r, logic [15:0] v);
    m_s[r] = v[15];
    m_z[r] = (v == 16'h0);
  endtask

  task automatic query_all(string tag, int r, bit ovf);
    for (int c = 0; c < 8; c++) begin
      pq_idx = 4'(r); pq_cc = 3'(c);
      #1;
      check(tag, {31'd0, pq_true}, {31'd0, expect_cc(m_s[r], m_z[r], ovf, c)});
    end
  endtask

  task automatic t_reset();
    for (int r = 0; r < 16; r++) begin
      m_s[r] = 0; m_z[r] = 1;
      pq_idx = 4'(r); pq_cc = 3'd1; #1;
      check("R1 zero after reset", {31'd0, pq_true}, 32'd1);
      pq_cc = 3'd3; #1;
      check("R1 not negative after reset", {31'd0, pq_true}, 32'd0);
    end
    check("R1 dynamic flags after reset", {24'd0, dyn_flags}, 32'd0);
  endtask

  task automatic t_short();
    sw_en = 1; sw_idx = 4'd3; sw_data = 16'h8001; model_set(3, 16'h8001);
    step();
    query_all("R2 R5 reg3 negative", 3, 0);
    sw_en = 1; sw_idx = 4'd4; sw_data = 16'h0005; model_set(4, 16'h0005);
    step();
    query_all("R2 R5 reg4 positive", 4, 0);
    query_all("R2 reg2 untouched", 2, 0);
    sw_en = 1; sw_idx = 4'd4; sw_data = 16'h0000; model_set(4, 16'h0000);
    step();
    query_all("R2 R5 reg4 zero", 4, 0);
  endtask

  task automatic t_long();
    lw_en = 1; lw_pair = 3'd2; lw_data = 32'h8000_0000;
    model_set(4, 16'h0000); model_set(5, 16'h8000);
    step();
    query_all("R3 pair2 low zero", 4, 0);
    query_all("R3 pair2 high negative", 5, 0);
    lw_en = 1; lw_pair = 3'd2; lw_data = 32'h0001_FFFF;
    model_set(4, 16'hFFFF); model_set(5, 16'h0001);
    step();
    query_all("R3 pair2 low negative", 4, 0);
    query_all("R3 pair2 high positive", 5, 0);
    query_all("R3 reg3 untouched", 3, 0);
  endtask

  task automatic t_collide();
    lw_en = 1; lw_pair = 3'd2; lw_data = 32'h8000_0001;
    sw_en = 1; sw_idx = 4'd5; sw_data = 16'h0000;
    model_set(4, 16'h0001); model_set(5, 16'h0000);
    step();
    query_all("R4 short wins reg5", 5, 0);
    query_all("R4 long still writes reg4", 4, 0);
  endtask

  task automatic t_write_through();
    sw_en = 1; sw_idx = 4'd7; sw_data = 16'hFFFF;
    pq_idx = 4'd7; pq_cc = 3'd3; #1;
    check("R6 same-cycle write seen", {31'd0, pq_true}, 32'd1);
    bq_idx = 4'd7; bq_cc = 3'd1; #1;
    check("R6 branch port same-cycle", {31'd0, bq_take}, 32'd0);
    model_set(7, 16'hFFFF);
    step();
    query_all("R6 after edge", 7, 0);
  endtask

  task automatic t_overflow();
    ovf_set = 4'b0010;
    step();
    check("R7 overflow set", {24'd0, dyn_flags}, 32'h02);
    pq_idx = 4'd0; pq_cc = 3'd7; #1;
    check("R5 overflow code true", {31'd0, pq_true}, 32'd1);
    step(); step(); step();
    check("R7 overflow sticky", {24'd0, dyn_flags}, 32'h02);
    ovf_clr = 4'b0010;
    step();
    check("R7 overflow cleared", {24'd0, dyn_flags}, 32'h00);
    #1;
    check("R5 overflow code false", {31'd0, pq_true}, 32'd0);
    ovf_set = 4'b0001; ovf_clr = 4'b0001;
    step();
    check("R7 set beats clear", {24'd0, dyn_flags}, 32'h01);
    ovf_clr = 4'b0001;
    step();
    check("R7 cleared again", {24'd0, dyn_flags}, 32'h00);
  endtask

  task automatic t_loop();
    loop_mask = 4'b0101; loop_val = 4'b1111;
    step();
    check("R8 masked loop write", {24'd0, dyn_flags}, 32'h50);
    loop_mask = 4'b0100; loop_val = 4'b0000;
    step();
    check("R8 single loop bit cleared", {24'd0, dyn_flags}, 32'h10);
  endtask

  task automatic t_restore();
    rst_ld_en = 1; rst_ld_val = 8'hA6; ovf_set = 4'hF; loop_mask = 4'hF; loop_val = 4'h0;
    step();
    check("R9 restore overrides datapath", {24'd0, dyn_flags}, 32'hA6);
    rst_ld_en = 1; rst_ld_val = 8'h00;
    step();
    check("R9 restore to zero", {24'd0, dyn_flags}, 32'h00);
  endtask

  task automatic t_two_ports();
    pq_idx = 4'd3; pq_cc = 3'd3;
    bq_idx = 4'd4; bq_cc = 3'd5; #1;
    check("R10 predicate port reg3 negative", {31'd0, pq_true}, {31'd0, expect_cc(m_s[3], m_z[3], 0, 3)});
    check("R10 branch port reg4 positive", {31'd0, bq_take}, {31'd0, expect_cc(m_s[4], m_z[4], 0, 5)});
    bq_idx = 4'd5; bq_cc = 3'd1; #1;
    check("R10 branch port reg5 zero", {31'd0, bq_take}, {31'd0, expect_cc(m_s[5], m_z[5], 0, 1)});
  endtask

  initial begin
    #(PERIOD * 20000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_short();
    t_long();
    t_collide();
    t_write_through();
    t_overflow();
    t_loop();
    t_restore();
    t_two_ports();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule